// File: doc/BRIEF.md
# GCM Phase Control Sequencer

This block holds the phase that software selects for an authenticated-encryption (GCM) job inside a block-cipher unit. Software writes a 7-bit one-hot phase code. The block cleans malformed codes, accepts a new phase only while the unit is idle, and checks each change against a table of legal successors. A write that is refused leaves the phase unchanged and raises a sticky error flag.

Entering the initialization phase starts a short sequence. The block first asks the cipher datapath to encrypt for the hash subkey. When that result comes back, it loads it into the hash engine. It then asks for the encryption of the IV and loads that result too. The unit reports idle again only after both loads have finished. The cipher datapath and the hash multiplier sit outside this block and are seen only through request/ready, done and load strobes.

Top module: `gcm_phase_seq`

States of the init sequencer: `IS_IDLE`, `IS_KEY_REQ`, `IS_KEY_WAIT`, `IS_KEY_LOAD`, `IS_IV_REQ`, `IS_IV_WAIT`, `IS_IV_LOAD`. The transitions are as follows:
- IDLE→KEY_REQ on an accepted write of the init phase.
- KEY_REQ→KEY_WAIT on cipher ready.
- KEY_WAIT→KEY_LOAD on cipher done.
- KEY_LOAD→IV_REQ unconditionally.
- IV_REQ→IV_WAIT on ready.
- IV_WAIT→IV_LOAD on done.
- IV_LOAD→IDLE unconditionally.

## Requirements
- R1: After reset the phase output is init (7'b000_0001), idle_o is 1, and cipher_req_o, err_o and both load strobes are 0.
- R2: Phase codes are one-hot with this bit order: bit0 init, bit1 restore, bit2 AAD, bit3 text, bit4 save, bit5 length, bit6 tag.
- R3: A written code that is zero or has more than one bit set is treated as init.
- R4: With GCM_EN = 0, every written code is treated as init, so the phase output is always init.
- R5: Init is a legal target from every phase. The other legal successors depend on the current phase:
  - init: restore, AAD, text.
  - restore: AAD, text.
  - AAD: text, save, length.
  - text: save, length.
  - length: tag.
  - save and tag: nothing besides init.
- R6: A write of a target that is not a legal successor is ignored: the phase is kept and err_o is set one cycle later. err_o stays set until the next accepted write, which clears it.
- R7: A write while idle_o is 0 is ignored and sets err_o, whether the unit is busy or the init sequence is running.
- R8: An accepted write of init makes cipher_req_o rise on the next cycle with cipher_sel_o = 0 (subkey). The IV request (cipher_sel_o = 1) is issued only after the subkey result has been loaded.
- R9: cipher_req_o and cipher_sel_o hold steady until cipher_ready_i is seen high.
- R10: ghash_hkey_load_o and then ghash_j0_load_o each pulse for exactly one cycle, never together, with ghash_data_o equal to the subkey result and the IV result respectively.
- R11: idle_o is 0 from the cycle after an init write is accepted until the IV load has finished, and is 0 whenever unit_busy_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Phase write strobe |
| wr_phase_i | input | 7 | Written phase code |
| unit_busy_i | input | 1 | Rest of the cipher unit is busy |
| cipher_req_o | output | 1 | Cipher request valid |
| cipher_sel_o | output | 1 | 0 = subkey request, 1 = IV request |
| cipher_ready_i | input | 1 | Cipher accepts request |
| cipher_done_i | input | 1 | Cipher result valid |
| cipher_res_i | input | BLK_W | Cipher result block |
| ghash_hkey_load_o | output | 1 | Load subkey into hash engine |
| ghash_j0_load_o | output | 1 | Load encrypted IV into hash engine |
| ghash_data_o | output | BLK_W | Block presented with the load strobes |
| phase_o | output | 7 | Current one-hot phase |
| idle_o | output | 1 | Unit idle, new phase write allowed |
| err_o | output | 1 | Sticky refused-write flag |

## Verification
The assertions assume that the cipher model raises cipher_done_i only after it has accepted a request, and only once per request. They also assume that cipher_ready_i does not depend on the request being withdrawn. The bench's cipher responder meets both conditions: it waits for a request, grants ready once after a programmed latency, and returns exactly one done pulse after a second latency. The sweep writes all 128 codes from every phase. It always waits for idle_o before moving on, except in the tests that deliberately write while the unit is busy.

// File: rtl/gcm_phase_pkg.sv
package gcm_phase_pkg;

    localparam int PHASE_W = 7;
    localparam int CNT_W   = $clog2(PHASE_W + 1);

    typedef enum logic [PHASE_W-1:0] {
        PH_INIT    = 7'b000_0001,
        PH_RESTORE = 7'b000_0010,
        PH_AAD     = 7'b000_0100,
        PH_TEXT    = 7'b000_1000,
        PH_SAVE    = 7'b001_0000,
        PH_LEN     = 7'b010_0000,
        PH_TAG     = 7'b100_0000
    } phase_e;

    typedef enum logic [2:0] {
        IS_IDLE,
        IS_KEY_REQ,
        IS_KEY_WAIT,
        IS_KEY_LOAD,
        IS_IV_REQ,
        IS_IV_WAIT,
        IS_IV_LOAD
    } init_st_e;

endpackage

// File: rtl/gcm_phase_clean.sv
module gcm_phase_clean
    import gcm_phase_pkg::*;
#(
    parameter bit GCM_EN = 1'b1
) (
    input  logic [PHASE_W-1:0] raw_i,
    output phase_e             clean_o
);

    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < PHASE_W; i++) begin
            ones = ones + CNT_W'(raw_i[i]);
        end
    end

    // Only a single-bit code survives; everything else restarts the job.
    always_comb begin
        if (GCM_EN && (ones == CNT_W'(1))) begin
            clean_o = phase_e'(raw_i);
        end else begin
            clean_o = PH_INIT;
        end
    end

endmodule

// File: rtl/gcm_phase_succ.sv
module gcm_phase_succ
    import gcm_phase_pkg::*;
(
    input  phase_e cur_i,
    input  phase_e nxt_i,
    output logic   ok_o
);

    logic [PHASE_W-1:0] legal;

    always_comb begin
        unique case (cur_i)
            PH_INIT:    legal = PH_INIT | PH_RESTORE | PH_AAD | PH_TEXT;
            PH_RESTORE: legal = PH_INIT | PH_AAD | PH_TEXT;
            PH_AAD:     legal = PH_INIT | PH_TEXT | PH_SAVE | PH_LEN;
            PH_TEXT:    legal = PH_INIT | PH_SAVE | PH_LEN;
            PH_SAVE:    legal = PH_INIT;
            PH_LEN:     legal = PH_INIT | PH_TAG;
            PH_TAG:     legal = PH_INIT;
            default:    legal = PH_INIT;
        endcase
    end

    assign ok_o = |(legal & nxt_i);

endmodule

// File: rtl/gcm_init_seq.sv
module gcm_init_seq
    import gcm_phase_pkg::*;
#(
    parameter int BLK_W = 128
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    output logic             cipher_req_o,
    output logic             cipher_sel_o,
    input  logic             cipher_ready_i,
    input  logic             cipher_done_i,
    input  logic [BLK_W-1:0] cipher_res_i,
    output logic             hkey_load_o,
    output logic             j0_load_o,
    output logic [BLK_W-1:0] load_data_o,
    output logic             busy_o
);

    init_st_e         st_q, st_d;
    logic [BLK_W-1:0] res_q;
    logic             waiting;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= IS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IS_IDLE:     if (start_i)        st_d = IS_KEY_REQ;
            IS_KEY_REQ:  if (cipher_ready_i) st_d = IS_KEY_WAIT;
            IS_KEY_WAIT: if (cipher_done_i)  st_d = IS_KEY_LOAD;
            IS_KEY_LOAD:                     st_d = IS_IV_REQ;
            IS_IV_REQ:   if (cipher_ready_i) st_d = IS_IV_WAIT;
            IS_IV_WAIT:  if (cipher_done_i)  st_d = IS_IV_LOAD;
            IS_IV_LOAD:                      st_d = IS_IDLE;
            default:                         st_d = IS_IDLE;
        endcase
    end

    assign waiting = (st_q == IS_KEY_WAIT) || (st_q == IS_IV_WAIT);

    // Result capture: a done pulse outside a wait state is dropped.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else if (waiting && cipher_done_i) begin
            res_q <= cipher_res_i;
        end
    end

    // Outputs
    always_comb begin
        cipher_req_o = 1'b0;
        cipher_sel_o = 1'b0;
        hkey_load_o  = 1'b0;
        j0_load_o    = 1'b0;
        unique case (st_q)
            IS_KEY_REQ: cipher_req_o = 1'b1;
            IS_IV_REQ: begin
                cipher_req_o = 1'b1;
                cipher_sel_o = 1'b1;
            end
            IS_KEY_LOAD: hkey_load_o = 1'b1;
            IS_IV_LOAD:  j0_load_o   = 1'b1;
            default: ;
        endcase
    end

    assign load_data_o = res_q;
    assign busy_o      = (st_q != IS_IDLE);

endmodule

// File: rtl/gcm_phase_seq.sv
module gcm_phase_seq
    import gcm_phase_pkg::*;
#(
    parameter bit GCM_EN = 1'b1,
    parameter int BLK_W  = 128
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_valid_i,
    input  logic [PHASE_W-1:0] wr_phase_i,
    input  logic               unit_busy_i,
    output logic               cipher_req_o,
    output logic               cipher_sel_o,
    input  logic               cipher_ready_i,
    input  logic               cipher_done_i,
    input  logic [BLK_W-1:0]   cipher_res_i,
    output logic               ghash_hkey_load_o,
    output logic               ghash_j0_load_o,
    output logic [BLK_W-1:0]   ghash_data_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic               idle_o,
    output logic               err_o
);

    phase_e wr_clean;
    phase_e phase_q;
    logic   succ_ok;
    logic   seq_busy;
    logic   accept;
    logic   seq_start;
    logic   err_q;

    gcm_phase_clean #(.GCM_EN(GCM_EN)) u_clean (
        .raw_i   (wr_phase_i),
        .clean_o (wr_clean)
    );

    gcm_phase_succ u_succ (
        .cur_i (phase_q),
        .nxt_i (wr_clean),
        .ok_o  (succ_ok)
    );

    assign idle_o    = !seq_busy && !unit_busy_i;
    assign accept    = wr_valid_i && idle_o && succ_ok;
    assign seq_start = accept && (wr_clean == PH_INIT);

    // Phase and sticky error register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= PH_INIT;
            err_q   <= 1'b0;
        end else if (wr_valid_i) begin
            err_q <= !accept;
            if (accept) begin
                phase_q <= wr_clean;
            end
        end
    end

    gcm_init_seq #(.BLK_W(BLK_W)) u_seq (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .start_i        (seq_start),
        .cipher_req_o   (cipher_req_o),
        .cipher_sel_o   (cipher_sel_o),
        .cipher_ready_i (cipher_ready_i),
        .cipher_done_i  (cipher_done_i),
        .cipher_res_i   (cipher_res_i),
        .hkey_load_o    (ghash_hkey_load_o),
        .j0_load_o      (ghash_j0_load_o),
        .load_data_o    (ghash_data_o),
        .busy_o         (seq_busy)
    );

    assign phase_o = phase_q;
    assign err_o   = err_q;

endmodule

// File: rtl/gcm_phase_seq_chk.sv
module gcm_phase_seq_chk
    import gcm_phase_pkg::*;
#(
    parameter bit GCM_EN = 1'b1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               wr_valid_i,
    input logic               cipher_req_o,
    input logic               cipher_sel_o,
    input logic               cipher_ready_i,
    input logic               ghash_hkey_load_o,
    input logic               ghash_j0_load_o,
    input logic [PHASE_W-1:0] phase_o,
    input logic               idle_o,
    input logic               err_o
);

    // R2
    phase_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(phase_o) == 1);

    // R5
    phase_moves_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(phase_o) |-> ($past(wr_valid_i) && $past(idle_o)));

    // R6
    err_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> $past(wr_valid_i));

    // R7
    busy_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_valid_i && !idle_o) |=> ($stable(phase_o) && err_o));

    // R9
    req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cipher_req_o && !cipher_ready_i) |=> (cipher_req_o && $stable(cipher_sel_o)));

    // R10
    hkey_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ghash_hkey_load_o |=> !ghash_hkey_load_o);

    // R10
    j0_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ghash_j0_load_o |=> !ghash_j0_load_o);

    // R10
    loads_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ghash_hkey_load_o && ghash_j0_load_o));

    // R8
    iv_after_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cipher_req_o && cipher_sel_o) |-> $past(ghash_hkey_load_o));

    // R11
    not_idle_in_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cipher_req_o || ghash_hkey_load_o || ghash_j0_load_o) |-> !idle_o);

    generate
        if (!GCM_EN) begin : g_off
            // R4
            phase_fixed_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                phase_o == PH_INIT);
        end
    endgenerate

endmodule

bind gcm_phase_seq gcm_phase_seq_chk #(.GCM_EN(GCM_EN)) u_chk (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .wr_valid_i        (wr_valid_i),
    .cipher_req_o      (cipher_req_o),
    .cipher_sel_o      (cipher_sel_o),
    .cipher_ready_i    (cipher_ready_i),
    .ghash_hkey_load_o (ghash_hkey_load_o),
    .ghash_j0_load_o   (ghash_j0_load_o),
    .phase_o           (phase_o),
    .idle_o            (idle_o),
    .err_o             (err_o)
);

// File: tb/sim_gcm_phase_seq.sv
`timescale 1ns/1ps
module sim_gcm_phase_seq;

    localparam int BW = 16;
    localparam logic [6:0] P_INIT = 7'h01, P_RST = 7'h02, P_AAD = 7'h04, P_TEXT = 7'h08,
                           P_SAVE = 7'h10, P_LEN = 7'h20, P_TAG = 7'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          wr_valid = 1'b0;
    logic [6:0]    wr_phase = '0;
    logic          ubusy = 1'b0;
    logic          c_ready = 1'b0, c_done = 1'b0;
    logic [BW-1:0] c_res = '0;
    logic          c_req, c_sel, hk_ld, j0_ld, idle, err;
    logic [BW-1:0] gdata;
    logic [6:0]    phase;

    gcm_phase_seq #(.GCM_EN(1'b1), .BLK_W(BW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_phase_i(wr_phase),
        .unit_busy_i(ubusy), .cipher_req_o(c_req), .cipher_sel_o(c_sel),
        .cipher_ready_i(c_ready), .cipher_done_i(c_done), .cipher_res_i(c_res),
        .ghash_hkey_load_o(hk_ld), .ghash_j0_load_o(j0_ld), .ghash_data_o(gdata),
        .phase_o(phase), .idle_o(idle), .err_o(err));

    // Second instance with GCM support off; its cipher side answers at once.
    logic          w1_valid = 1'b0;
    logic [6:0]    w1_phase = '0;
    logic          r1_req, r1_sel, r1_hk, r1_j0, r1_idle, r1_err;
    logic [BW-1:0] r1_data;
    logic [6:0]    r1_phase;

    gcm_phase_seq #(.GCM_EN(1'b0), .BLK_W(BW)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(w1_valid), .wr_phase_i(w1_phase),
        .unit_busy_i(1'b0), .cipher_req_o(r1_req), .cipher_sel_o(r1_sel),
        .cipher_ready_i(1'b1), .cipher_done_i(1'b1), .cipher_res_i(16'h0F0F),
        .ghash_hkey_load_o(r1_hk), .ghash_j0_load_o(r1_j0), .ghash_data_o(r1_data),
        .phase_o(r1_phase), .idle_o(r1_idle), .err_o(r1_err));

    int n_chk = 0, n_fail = 0;
    int rdy_lat = 0, done_lat = 0;
    int seed = 1;
    logic [BW-1:0] sent_key = '0, sent_iv = '0;
    int hk_cnt = 0, j0_cnt = 0;
    int mon_bad = 0;
    bit done_flag = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Cipher responder for u0
    initial begin
        forever begin
            @(negedge clk);
            if (c_req) begin
                logic s;
                for (int i = 0; i < rdy_lat; i++) @(negedge clk);
                s = c_sel;
                c_ready = 1'b1;
                @(negedge clk);
                c_ready = 1'b0;
                for (int i = 0; i < done_lat; i++) @(negedge clk);
                seed = seed + 7;
                c_res = s ? ~BW'(seed * 3) : BW'(seed * 5 + 1);
                if (s) sent_iv = c_res; else sent_key = c_res;
                c_done = 1'b1;
                @(negedge clk);
                c_done = 1'b0;
            end
        end
    end

    // Load monitor for u0 (R8, R10)
    logic prev_hk = 1'b0, prev_j0 = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hk_ld) begin
                hk_cnt++;
                if (gdata !== sent_key || prev_hk || j0_ld) mon_bad++;
            end
            if (j0_ld) begin
                j0_cnt++;
                if (gdata !== sent_iv || prev_j0 || hk_cnt != j0_cnt) mon_bad++;
            end
        end
        prev_hk = hk_ld;
        prev_j0 = j0_ld;
    end

    function automatic logic [6:0] clean_exp(input logic [6:0] v);
        return ($countones(v) == 1) ? v : P_INIT;
    endfunction

    function automatic bit legal_exp(input logic [6:0] c, input logic [6:0] n);
        case (c)
            P_INIT:  return n inside {P_INIT, P_RST, P_AAD, P_TEXT};
            P_RST:   return n inside {P_INIT, P_AAD, P_TEXT};
            P_AAD:   return n inside {P_INIT, P_TEXT, P_SAVE, P_LEN};
            P_TEXT:  return n inside {P_INIT, P_SAVE, P_LEN};
            P_LEN:   return n inside {P_INIT, P_TAG};
            default: return n == P_INIT;
        endcase
    endfunction

    task automatic wr(input logic [6:0] v);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_phase = v;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int k = 0;
        while (!idle && k < 300) begin
            @(negedge clk);
            k++;
        end
        check(idle, req, 32'(idle), 32'h1);
    endtask

    task automatic init_run(input string req);
        int h0, j00;
        h0 = hk_cnt;
        j00 = j0_cnt;
        wr(P_INIT);
        check(c_req === 1'b1 && c_sel === 1'b0 && idle === 1'b0, {req, " R8 R11 key request"},
              {29'd0, c_req, c_sel, idle}, 32'h4);
        wait_idle({req, " R11"});
        check(hk_cnt == h0 + 1 && j0_cnt == j00 + 1, {req, " R10 loads"},
              32'((hk_cnt - h0) * 16 + (j0_cnt - j00)), 32'h11);
    endtask

    task automatic go_to(input logic [6:0] p);
        init_run("R8 setup");
        case (p)
            P_RST:  wr(P_RST);
            P_AAD:  wr(P_AAD);
            P_TEXT: wr(P_TEXT);
            P_SAVE: begin wr(P_AAD); wr(P_SAVE); end
            P_LEN:  begin wr(P_TEXT); wr(P_LEN); end
            P_TAG:  begin wr(P_TEXT); wr(P_LEN); wr(P_TAG); end
            default: ;
        endcase
        check(phase === p && err === 1'b0, "R2 R5 path", {25'd0, phase}, {25'd0, p});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(phase === P_INIT && idle && !c_req && !err && !hk_ld && !j0_ld, "R1 reset",
              {20'd0, phase, c_req, err, hk_ld, j0_ld, idle}, {20'd0, P_INIT, 5'b00001});

        // R8 R10 R11: full init with latencies
        rdy_lat = 2; done_lat = 3;
        init_run("R8 latency");
        check(mon_bad == 0, "R10 data/order", 32'(mon_bad), 32'h0);

        // R9: request held while ready is low
        rdy_lat = 3; done_lat = 1;
        wr(P_INIT);
        for (int i = 0; i < 3; i++) begin
            check(c_req === 1'b1 && c_sel === 1'b0, "R9 hold", {30'd0, c_req, c_sel}, 32'h2);
            @(negedge clk);
        end
        // R7: write during the running sequence
        check(idle === 1'b0, "R11 busy in sequence", 32'(idle), 32'h0);
        wr(P_AAD);
        check(phase === P_INIT && err === 1'b1, "R7 write in sequence", {24'd0, err, phase}, {24'd1, P_INIT});
        wait_idle("R11 end");
        rdy_lat = 0; done_lat = 0;

        // R7 and R11: unit busy
        ubusy = 1'b1;
        @(negedge clk);
        check(idle === 1'b0, "R11 unit busy", 32'(idle), 32'h0);
        wr(P_TEXT);
        check(phase === P_INIT && err === 1'b1, "R7 busy write", {24'd0, err, phase}, {24'd1, P_INIT});
        ubusy = 1'b0;
        repeat (3) @(negedge clk);
        check(err === 1'b1, "R6 sticky", 32'(err), 32'h1);
        wr(P_AAD);
        check(phase === P_AAD && err === 1'b0, "R6 clear", {24'd0, err, phase}, {24'd0, P_AAD});

        // R2 R3 R5 R6: every code from every phase
        for (int s = 0; s < 7; s++) begin
            for (int v = 0; v < 128; v++) begin
                logic [6:0] src, cv, ep;
                bit ok;
                src = 7'(1 << s);
                go_to(src);
                cv = clean_exp(7'(v));
                ok = legal_exp(src, cv);
                ep = ok ? cv : src;
                wr(7'(v));
                check(phase === ep && err === !ok, "R3 R5 R6 sweep",
                      {24'd0, err, phase}, {24'd0, !ok, ep});
                if (ok && cv == P_INIT) wait_idle("R3 R11 sweep");
            end
        end
        check(mon_bad == 0, "R10 sweep loads", 32'(mon_bad), 32'h0);

        // R4: GCM disabled instance
        for (int v = 0; v < 128; v++) begin
            @(negedge clk);
            w1_valid = 1'b1;
            w1_phase = 7'(v);
            @(negedge clk);
            w1_valid = 1'b0;
            check(r1_phase === P_INIT && r1_err === 1'b0, "R4 disabled",
                  {24'd0, r1_err, r1_phase}, {24'd0, P_INIT});
            for (int k = 0; k < 20 && !r1_idle; k++) @(negedge clk);
        end

        done_flag = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule